// File: doc/BRIEF.md
# Frame-Aligned Internal Command Scheduler

This block decides when periodic internal commands, such as ramp or waveform-table steps, go out relative to data acquisition. Time is counted in multiplexing frames. A single-cycle frame-start pulse marks the start of each frame, and every issue decision is taken on the clock edge where that pulse is high. A frame counter wraps at a programmable step period. An internal command becomes due on the frame whose count equals a programmable step phase. Moving the phase therefore shifts the internal issue point against the data frames, and the step period alone sets the refresh rate.

A data command that falls due on a frame always goes out first as a one-cycle strobe. An internal command due on the same frame follows one cycle later. Internal commands leave through a valid/ready stream. Once offered, the value is held stable with valid high until ready accepts it. A due tick that arrives while an internal command is still held or waiting counts as a collision. No new command is offered, but the ramp value still steps, so the next command that does go out carries the correct value. The header output reports the last value the consumer accepted. Skipped or still-pending values never reach it.

Top module: `frame_cmd_sched`

## Requirements
- R1: After reset, `data_cmd_o`, `int_valid_o`, `int_value_o` and `hdr_o` are all zero.
- R2: `data_cmd_o` is high for exactly the one cycle after an edge where `arz_i` and `data_due_i` are both high, and is low otherwise.
- R3: A frame counter starts at 0 after reset. It advances on every `arz_i` edge and returns to 0 when the incremented value reaches `step_period_i`. An internal command is due on an `arz_i` edge whose count before the advance equals `step_phase_i`. With no data command due on that frame, `int_valid_o` rises in the following cycle.
- R4: While `data_rate_i` is below 2, no internal command is offered and the ramp value does not step, although the frame counter keeps counting.
- R5: When a data command and an internal command fall due on the same frame edge, `data_cmd_o` is high in the first cycle after that edge and `int_valid_o` rises in the second cycle.
- R6: Each due tick offers the current ramp value, then steps it by `ramp_step_i`. When the stepped sum, computed one bit wider, exceeds `ramp_max_i`, the value wraps to `ramp_min_i`.
- R7: On a due tick, the tick is a collision if an internal command is waiting for its deferred slot, or if `int_valid_o` is high and `int_ready_i` is low. A collision offers nothing new and still steps the ramp value.
- R8: `hdr_o` takes `int_value_o` on each edge where `int_valid_o` and `int_ready_i` are both high, and holds its value otherwise, including across collisions.
- R9: While `int_valid_o` is high and `int_ready_i` is low, `int_valid_o` stays high and `int_value_o` stays unchanged on the next cycle.
- R10: When `step_period_i` is 0, or `step_phase_i` is not below `step_period_i`, no internal command is ever due.
- R11: While `ramp_en_i` is low, the ramp value is loaded with `ramp_min_i` every cycle and no internal command is offered.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arz_i | input | 1 | Frame-start pulse, one cycle per multiplexing frame |
| data_rate_i | input | RW | Readout rate in frames; internal commands need at least 2 |
| step_period_i | input | CW | Internal step period in frames |
| step_phase_i | input | CW | Frame count at which an internal step is due |
| ramp_en_i | input | 1 | Ramp enable; low reloads the minimum |
| ramp_min_i | input | VW | Ramp lower limit and wrap target |
| ramp_max_i | input | VW | Ramp upper limit |
| ramp_step_i | input | VW | Ramp increment per due tick |
| data_due_i | input | 1 | A data command is due on this frame, sampled with `arz_i` |
| int_ready_i | input | 1 | Consumer accepts the internal command |
| data_cmd_o | output | 1 | Data-command issue strobe |
| int_valid_o | output | 1 | Internal command offered |
| int_value_o | output | VW | Value carried by the internal command |
| hdr_o | output | VW | Last accepted internal value, for the frame header |

## Verification
Two events can land on the same frame edge. One is a data command and an internal command falling due together. The other is an internal due tick meeting a command that the consumer is still holding back.

The first is provoked by raising `data_due_i` on a due frame. The check is that the data strobe comes one cycle ahead of the internal valid. The second is provoked by holding ready low across two due ticks. The check is that the held value stays put, the header does not move, and the next command carries a value stepped twice.

Constrained-random frames with random gaps, due flags and ready patterns are compared cycle by cycle against a frame-level reference model in the bench.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {
    ISS_NONE   = 2'd0,
    ISS_DIRECT = 2'd1,
    ISS_DEFER  = 2'd2,
    ISS_SKIP   = 2'd3
  } iss_kind_e;

  localparam int unsigned MIN_RATE = 2;
endpackage

// File: rtl/fcs_phase_gen.sv
module fcs_phase_gen #(
  parameter int unsigned CW = 8,
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arz_i,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] phase_i,
  input  logic [RW-1:0] rate_i,
  input  logic          en_i,
  output logic          tick_o
);
  import fcs_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [CW:0]   cnt_inc;
  logic          rate_ok;
  logic          period_ok;

  assign cnt_inc   = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign rate_ok   = (rate_i >= RW'(MIN_RATE));
  assign period_ok = (period_i != '0) && (phase_i < period_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (arz_i) begin
      if (cnt_inc >= {1'b0, period_i}) cnt_q <= '0;
      else                             cnt_q <= cnt_inc[CW-1:0];
    end
  end

  assign tick_o = arz_i && en_i && rate_ok && period_ok && (cnt_q == phase_i);
endmodule

// File: rtl/fcs_ramp_step.sv
module fcs_ramp_step #(
  parameter int unsigned VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          adv_i,
  input  logic [VW-1:0] min_i,
  input  logic [VW-1:0] max_i,
  input  logic [VW-1:0] step_i,
  output logic [VW-1:0] cur_o
);
  logic [VW:0]   sum;
  logic [VW-1:0] nxt;

  assign sum = {1'b0, cur_o} + {1'b0, step_i};
  assign nxt = (sum > {1'b0, max_i}) ? min_i : sum[VW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)     cur_o <= '0;
    else if (!en_i) cur_o <= min_i;
    else if (adv_i) cur_o <= nxt;
  end
endmodule

// File: rtl/fcs_issue.sv
module fcs_issue #(
  parameter int unsigned VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arz_i,
  input  logic          data_due_i,
  input  logic          tick_i,
  input  logic [VW-1:0] cur_i,
  input  logic          int_ready_i,
  output logic          data_cmd_o,
  output logic          int_valid_o,
  output logic [VW-1:0] int_value_o,
  output logic [VW-1:0] hdr_o
);
  import fcs_pkg::*;

  logic          defer_q;
  logic [VW-1:0] stage_q;
  logic          accept;
  logic          busy;
  iss_kind_e     kind;

  assign accept = int_valid_o && int_ready_i;
  assign busy   = defer_q || (int_valid_o && !int_ready_i);

  always_comb begin
    if (!tick_i)         kind = ISS_NONE;
    else if (busy)       kind = ISS_SKIP;
    else if (data_due_i) kind = ISS_DEFER;
    else                 kind = ISS_DIRECT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_cmd_o  <= 1'b0;
      int_valid_o <= 1'b0;
      int_value_o <= '0;
      hdr_o       <= '0;
      defer_q     <= 1'b0;
      stage_q     <= '0;
    end else begin
      data_cmd_o <= arz_i && data_due_i;
      if (accept) begin
        hdr_o       <= int_value_o;
        int_valid_o <= 1'b0;
      end
      if (defer_q) begin
        int_valid_o <= 1'b1;
        int_value_o <= stage_q;
        defer_q     <= 1'b0;
      end
      case (kind)
        ISS_DIRECT: begin
          int_valid_o <= 1'b1;
          int_value_o <= cur_i;
        end
        ISS_DEFER: begin
          defer_q <= 1'b1;
          stage_q <= cur_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/frame_cmd_sched.sv
module frame_cmd_sched #(
  parameter int unsigned VW = 16,
  parameter int unsigned CW = 8,
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arz_i,
  input  logic [RW-1:0] data_rate_i,
  input  logic [CW-1:0] step_period_i,
  input  logic [CW-1:0] step_phase_i,
  input  logic          ramp_en_i,
  input  logic [VW-1:0] ramp_min_i,
  input  logic [VW-1:0] ramp_max_i,
  input  logic [VW-1:0] ramp_step_i,
  input  logic          data_due_i,
  input  logic          int_ready_i,
  output logic          data_cmd_o,
  output logic          int_valid_o,
  output logic [VW-1:0] int_value_o,
  output logic [VW-1:0] hdr_o
);
  logic          tick;
  logic [VW-1:0] ramp_cur;

  fcs_phase_gen #(.CW(CW), .RW(RW)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .arz_i    (arz_i),
    .period_i (step_period_i),
    .phase_i  (step_phase_i),
    .rate_i   (data_rate_i),
    .en_i     (ramp_en_i),
    .tick_o   (tick)
  );

  fcs_ramp_step #(.VW(VW)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ramp_en_i),
    .adv_i  (tick),
    .min_i  (ramp_min_i),
    .max_i  (ramp_max_i),
    .step_i (ramp_step_i),
    .cur_o  (ramp_cur)
  );

  fcs_issue #(.VW(VW)) u_issue (
    .clk         (clk),
    .rst_n       (rst_n),
    .arz_i       (arz_i),
    .data_due_i  (data_due_i),
    .tick_i      (tick),
    .cur_i       (ramp_cur),
    .int_ready_i (int_ready_i),
    .data_cmd_o  (data_cmd_o),
    .int_valid_o (int_valid_o),
    .int_value_o (int_value_o),
    .hdr_o       (hdr_o)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int unsigned VW = 16,
  parameter int unsigned RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arz_i,
  input logic          data_due_i,
  input logic [RW-1:0] data_rate_i,
  input logic          int_ready_i,
  input logic          data_cmd_o,
  input logic          int_valid_o,
  input logic [VW-1:0] int_value_o,
  input logic [VW-1:0] hdr_o
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid_o && !int_ready_i) |=> (int_valid_o && $stable(int_value_o))); // R9

  AST_DATA_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    data_cmd_o |-> $past(arz_i && data_due_i)); // R2

  AST_HDR_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hdr_o) |-> $past(int_valid_o && int_ready_i)); // R8

  AST_ISSUE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_valid_o) |-> ($past(arz_i) || $past(data_cmd_o))); // R3

  AST_SLOW_RATE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(int_valid_o) && !$past(data_cmd_o)) |-> ($past(data_rate_i) >= RW'(2))); // R4
endmodule

bind frame_cmd_sched fcs_checker #(.VW(VW), .RW(RW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .arz_i       (arz_i),
  .data_due_i  (data_due_i),
  .data_rate_i (data_rate_i),
  .int_ready_i (int_ready_i),
  .data_cmd_o  (data_cmd_o),
  .int_valid_o (int_valid_o),
  .int_value_o (int_value_o),
  .hdr_o       (hdr_o)
);

// File: tb/frame_cmd_sched_tb.sv
`timescale 1ns/1ps
module frame_cmd_sched_tb;
  localparam int unsigned VW = 16;
  localparam int unsigned CW = 8;
  localparam int unsigned RW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arz = 1'b0;
  logic [RW-1:0] rate = 8'd2;
  logic [CW-1:0] per = 8'd1;
  logic [CW-1:0] ph = 8'd0;
  logic          en = 1'b0;
  logic [VW-1:0] rmin = 16'd10;
  logic [VW-1:0] rmax = 16'd100;
  logic [VW-1:0] rstep = 16'd5;
  logic          due = 1'b0;
  logic          rdy = 1'b0;
  logic          dcmd, ivld;
  logic [VW-1:0] ival, hdr;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frame_cmd_sched #(.VW(VW), .CW(CW), .RW(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arz_i(arz), .data_rate_i(rate),
    .step_period_i(per), .step_phase_i(ph), .ramp_en_i(en),
    .ramp_min_i(rmin), .ramp_max_i(rmax), .ramp_step_i(rstep),
    .data_due_i(due), .int_ready_i(rdy), .data_cmd_o(dcmd),
    .int_valid_o(ivld), .int_value_o(ival), .hdr_o(hdr)
  );

  // reference model built from the requirements
  logic [CW-1:0] m_cnt;
  logic [VW-1:0] m_ramp, m_val, m_stage, m_hdr;
  logic          m_v, m_def, m_dc;

  function automatic logic [VW-1:0] ramp_next(input logic [VW-1:0] c);
    logic [VW:0] s;
    s = {1'b0, c} + {1'b0, rstep};
    return (s > {1'b0, rmax}) ? rmin : s[VW-1:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_ramp = '0; m_val = '0; m_stage = '0; m_hdr = '0;
      m_v = 1'b0; m_def = 1'b0; m_dc = 1'b0;
    end else begin
      bit tick, busy, acc, old_def;
      tick = arz && en && (rate >= 2) && (per != 0) && (ph < per) && (m_cnt == ph);
      busy = m_def || (m_v && !rdy);
      acc = m_v && rdy;
      old_def = m_def;
      if (arz) m_cnt = ((m_cnt + 1) >= per) ? '0 : m_cnt + 1;
      m_dc = arz && due;
      if (acc) begin m_hdr = m_val; m_v = 1'b0; end
      if (old_def) begin m_v = 1'b1; m_val = m_stage; m_def = 1'b0; end
      if (!en) m_ramp = rmin;
      else if (tick) begin
        if (!busy) begin
          if (due) begin m_def = 1'b1; m_stage = m_ramp; end
          else begin m_v = 1'b1; m_val = m_ramp; end
        end
        m_ramp = ramp_next(m_ramp);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk((tag == "R5") ? "R5" : "R2", 32'(dcmd), 32'(m_dc), "data strobe");
    chk(tag, 32'(ivld), 32'(m_v), "int valid");
    if (m_v) chk((tag == "R7") ? "R7" : "R6", 32'(ival), 32'(m_val), "int value");
    chk("R8", 32'(hdr), 32'(m_hdr), "header");
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic frame(input bit d, input int gap);
    due = d; arz = 1'b1;
    step();
    arz = 1'b0; due = 1'b0;
    for (int i = 1; i < gap; i++) step();
  endtask

  initial begin
    #(5ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    repeat (3) @(negedge clk);
    chk("R1", 32'(dcmd), 0, "reset data strobe");
    chk("R1", 32'(ivld), 0, "reset valid");
    chk("R1", 32'(ival), 0, "reset value");
    chk("R1", 32'(hdr), 0, "reset header");
    rst_n = 1'b1;
    step();

    // R11: disabled ramp reloads minimum, nothing offered
    tag = "R11";
    for (int f = 0; f < 3; f++) frame(1'b0, 4);
    chk("R11", 32'(ivld), 0, "no issue when disabled");

    // R3/R6: period 4, phase 1, wrap near max
    tag = "R3"; en = 1'b1; per = 8'd4; ph = 8'd1; rmax = 16'd30; rdy = 1'b1;
    step();
    for (int f = 0; f < 24; f++) frame(1'b0, 4);
    tag = "R6"; per = 8'd1; ph = 8'd0;
    for (int f = 0; f < 8; f++) frame(1'b0, 3);
    rmax = 16'd100;

    // R5: data and internal due on the same frame
    tag = "R5"; en = 1'b0; step(); en = 1'b1; step();
    due = 1'b1; arz = 1'b1; step();
    arz = 1'b0; due = 1'b0;
    chk("R5", 32'(dcmd), 1, "data strobe first");
    chk("R5", 32'(ivld), 0, "internal not yet");
    step();
    chk("R5", 32'(ivld), 1, "internal follows");
    chk("R5", 32'(ival), 10, "internal value");
    step(); step();

    // R7/R9: collision while stalled
    tag = "R7"; rdy = 1'b0; en = 1'b0; step(); en = 1'b1; step();
    frame(1'b0, 3);
    chk("R7", 32'(ival), 10, "first offer");
    frame(1'b0, 3);
    chk("R9", 32'(ival), 10, "held during stall");
    chk("R9", 32'(ivld), 1, "valid held");
    chk("R8", 32'(hdr), 32'(m_hdr), "header unchanged on collision");
    rdy = 1'b1; step();
    chk("R8", 32'(hdr), 10, "header after accept");
    frame(1'b0, 3);
    chk("R7", 32'(ival), 20, "value stepped through collision");

    // R4: slow readout rate
    tag = "R4"; rate = 8'd1;
    for (int f = 0; f < 5; f++) frame(1'b0, 3);
    chk("R4", 32'(ivld), 0, "no issue at rate 1");
    rate = 8'd2; tag = "R6";
    frame(1'b0, 3);
    chk("R4", 32'(ival), 25, "ramp frozen at rate 1");

    // R10: unreachable phase and zero period
    tag = "R10"; per = 8'd3; ph = 8'd3;
    for (int f = 0; f < 6; f++) frame(1'b0, 3);
    per = 8'd0; ph = 8'd0;
    for (int f = 0; f < 4; f++) frame(1'b0, 3);
    chk("R10", 32'(ivld), 0, "never due");

    // random frames
    tag = "R3"; per = 8'd2; ph = 8'd0;
    for (int f = 0; f < 400; f++) begin
      if ((f % 50) == 0) begin
        per = CW'($urandom_range(1, 5));
        ph = CW'($urandom_range(0, 4));
        rstep = VW'($urandom_range(1, 40));
      end
      due = ($urandom_range(0, 2) == 0);
      rdy = ($urandom_range(0, 3) != 0);
      arz = 1'b1; step(); arz = 1'b0; due = 1'b0;
      for (int i = 0; i < int'($urandom_range(2, 5)); i++) begin
        rdy = ($urandom_range(0, 3) != 0);
        step();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule